// File: doc/BRIEF.md
# LCD Controller Register Slave

This block is the software-facing register file of a colour LCD controller. A host reaches it over a 32-bit bus addressed by word. Each access is taken in one cycle and answered one cycle later. The block holds the panel timing words, two frame base addresses, the control word, and the interrupt mask and status. It passes palette writes on to the display pipeline, keeps a copy of the palette for read-back, and answers a fixed identification window.

Several values go straight to the pixel pipeline. The panel width and height are worked out from fields of the first two timing words. The control word supplies the pixel depth code, the colour order and the endianness selects. A display-enable flag is raised only when both the enable bit and the power bit are set. Interrupt events from the pipeline set raw status bits, and the interrupt line is raised when any unmasked bit is set.

A strap input chooses an alternative address map in which the mask word and the control word trade places. The bus side is run by a two-state machine. ST_IDLE moves to ST_RESP when bus_sel is high, and the access is performed on that transition. ST_RESP always moves back to ST_IDLE, and bus_ack is high while the machine is in ST_RESP.

Top module: `lcd_regif`

## Requirements
- R1: A request is accepted when bus_sel is high while no response is pending. bus_ack is high for exactly the following cycle, and bus_rdata and bus_err are valid in that cycle. A bus_sel seen during the ack cycle is ignored.
- R2: Word offsets 0 to 3 are 32-bit read/write timing words. Offset 4 is the upper frame base and offset 5 is the lower frame base, both 32-bit read/write. Offset 6 is the interrupt mask, using bits 4:0. Offset 7 is the control word, using bits 11:0. Unused bits read as zero, and every one of these words resets to zero.
- R3: When strap_alt is high, word offsets 6 and 7 swap roles for both reads and writes.
- R4: panel_width is 16 × (timing0[7:2] + 1) and panel_height is timing1[9:0] + 1. After reset they are 16 and 1.
- R5: The control word drives the pipeline outputs: bit 0 is enable, bits 3:1 are bpp_code, bit 8 is bgr_order, bit 9 is be_byte, bit 10 is be_pixel and bit 11 is power. disp_en is high only when bits 0 and 11 are both set.
- R6: A 1 on bit i of int_evt sets raw status bit i. Offset 8 reads the raw status and offset 9 reads raw AND mask. Writing offset 10 clears each raw bit written as 1. An event in the same cycle as a clear leaves its bit set.
- R7: irq_out is high exactly when raw AND mask is nonzero.
- R8: Offsets 11 and 12 read the upper and lower frame base respectively.
- R9: Word offsets 0x3F8 to 0x3FF read the bytes 0x10, 0x11, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in that order, zero-extended. A write there changes nothing and sets bus_err.
- R10: Word offsets 0x80 to 0xFF are the palette, with entry = offset − 0x80. A write stores the word and drives pal_we high in the ack cycle, with pal_idx and pal_wdata. A read returns the stored word.
- R11: Any other offset reads as zero, ignores writes and sets bus_err. Writes to offsets 8, 9, 11 and 12 are ignored and set bus_err. A read of offset 10 returns zero with no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_alt | input | 1 | Selects the map with mask and control swapped |
| bus_sel | input | 1 | Access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Word offset |
| bus_wdata | input | 32 | Write data |
| bus_ack | output | 1 | Response cycle |
| bus_err | output | 1 | Access error, valid with bus_ack |
| bus_rdata | output | 32 | Read data, valid with bus_ack |
| int_evt | input | 5 | Interrupt event pulses |
| irq_out | output | 1 | Interrupt request |
| disp_en | output | 1 | Display enabled (enable and power both set) |
| bpp_code | output | 3 | Pixel depth code |
| bgr_order | output | 1 | Blue/red order select |
| be_byte | output | 1 | Big-endian byte order |
| be_pixel | output | 1 | Big-endian pixel order |
| panel_width | output | 11 | Pixels per line |
| panel_height | output | 11 | Lines per panel |
| upper_base | output | 32 | Upper frame base address |
| lower_base | output | 32 | Lower frame base address |
| pal_we | output | 1 | Palette write strobe |
| pal_idx | output | 7 | Palette entry |
| pal_wdata | output | 32 | Palette data |

## Verification
Every pipeline output is a direct function of stored state. A wrong timing, control, base or mask bit therefore shows on panel_width, panel_height, disp_en, bpp_code, the base outputs or irq_out in the cycle after the write that caused it, and the bench compares those outputs on every clock. A wrong raw status bit shows on irq_out as soon as its mask bit is set. It also shows on the next read of offset 8 or 9. A fault in decoding, the strap swap or palette storage shows only on bus_rdata or bus_err in the ack cycle of an access that touches the faulty word. For that reason the bench sweeps every mapped offset, the whole palette and a set of unmapped offsets, under both strap settings.

// File: rtl/lcd_regif_pkg.sv
package lcd_regif_pkg;

    typedef enum logic [1:0] {
        RGN_REG,
        RGN_PAL,
        RGN_ID,
        RGN_NONE
    } region_e;

    typedef enum logic {
        ST_IDLE,
        ST_RESP
    } bus_state_e;

    localparam logic [3:0] IDX_UBASE = 4'd4;
    localparam logic [3:0] IDX_LBASE = 4'd5;
    localparam logic [3:0] IDX_MASK  = 4'd6;
    localparam logic [3:0] IDX_CTRL  = 4'd7;
    localparam logic [3:0] IDX_RAW   = 4'd8;
    localparam logic [3:0] IDX_MIS   = 4'd9;
    localparam logic [3:0] IDX_CLR   = 4'd10;
    localparam logic [3:0] IDX_UCUR  = 4'd11;
    localparam logic [3:0] IDX_LCUR  = 4'd12;

    // Control word bit positions (decoded by the pixel pipeline)
    localparam int CB_EN    = 0;
    localparam int CB_BPP   = 1;
    localparam int CB_BGR   = 8;
    localparam int CB_BEBY  = 9;
    localparam int CB_BEPX  = 10;
    localparam int CB_PWR   = 11;

    function automatic logic [7:0] id_byte(input logic [2:0] n);
        logic [7:0] b;
        unique case (n)
            3'd0: b = 8'h10;
            3'd1: b = 8'h11;
            3'd2: b = 8'h04;
            3'd3: b = 8'h00;
            3'd4: b = 8'h0D;
            3'd5: b = 8'hF0;
            3'd6: b = 8'h05;
            default: b = 8'hB1;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/lcd_regif_decode.sv
module lcd_regif_decode
    import lcd_regif_pkg::*;
#(
    parameter int AW        = 10,
    parameter int NREG      = 13,
    parameter int PAL_BASE  = 128,
    parameter int PAL_DEPTH = 128,
    parameter int ID_BASE   = 1016,
    parameter int ID_WORDS  = 8
) (
    input  logic [AW-1:0] addr,
    input  logic          wr,
    input  logic          strap_alt,
    output region_e       region,
    output logic [3:0]    widx,
    output logic          err
);
    localparam int PAL_END = PAL_BASE + PAL_DEPTH;
    localparam int ID_END  = ID_BASE + ID_WORDS;

    logic [3:0] raw_idx;

    always_comb begin
        raw_idx = addr[3:0];
        widx    = raw_idx;
        if (strap_alt && raw_idx == IDX_MASK)      widx = IDX_CTRL;
        else if (strap_alt && raw_idx == IDX_CTRL) widx = IDX_MASK;

        region = RGN_NONE;
        err    = 1'b1;
        if (int'(addr) < NREG) begin
            region = RGN_REG;
            err    = wr && (widx == IDX_RAW || widx == IDX_MIS ||
                            widx == IDX_UCUR || widx == IDX_LCUR);
        end else if (int'(addr) >= PAL_BASE && int'(addr) < PAL_END) begin
            region = RGN_PAL;
            err    = 1'b0;
        end else if (int'(addr) >= ID_BASE && int'(addr) < ID_END) begin
            region = RGN_ID;
            err    = wr;
        end
    end

endmodule

// File: rtl/lcd_regif_palette.sv
module lcd_regif_palette #(
    parameter int DW    = 32,
    parameter int DEPTH = 128,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [IW-1:0] idx,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[idx] <= wdata;
    end

    assign rdata = mem[idx];

endmodule

// File: rtl/lcd_regif_irq.sv
module lcd_regif_irq #(
    parameter int NIRQ = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mask_we,
    input  logic            clr_we,
    input  logic [NIRQ-1:0] wbits,
    input  logic [NIRQ-1:0] evt,
    output logic [NIRQ-1:0] mask_q,
    output logic [NIRQ-1:0] raw_q,
    output logic            irq
);
    logic [NIRQ-1:0] clr_bits;

    assign clr_bits = clr_we ? wbits : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
            raw_q  <= '0;
        end else begin
            if (mask_we) mask_q <= wbits;
            raw_q <= (raw_q & ~clr_bits) | evt;
        end
    end

    assign irq = |(raw_q & mask_q);

    // R6
    raw_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(|evt) |=> ((raw_q & ~$past(raw_q)) == '0));

    // R6
    clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && !(|evt)) |=> ((raw_q & $past(wbits)) == '0));

endmodule

// File: rtl/lcd_regif.sv
module lcd_regif
    import lcd_regif_pkg::*;
#(
    parameter int DW        = 32,
    parameter int AW        = 10,
    parameter int NIRQ      = 5,
    parameter int CTRL_W    = 12,
    parameter int NTIM      = 4,
    parameter int PAL_BASE  = 128,
    parameter int PAL_DEPTH = 128,
    parameter int ID_BASE   = 1016,
    localparam int PIW      = $clog2(PAL_DEPTH),
    localparam int SW       = 11
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            strap_alt,
    input  logic            bus_sel,
    input  logic            bus_wr,
    input  logic [AW-1:0]   bus_addr,
    input  logic [DW-1:0]   bus_wdata,
    output logic            bus_ack,
    output logic            bus_err,
    output logic [DW-1:0]   bus_rdata,
    input  logic [NIRQ-1:0] int_evt,
    output logic            irq_out,
    output logic            disp_en,
    output logic [2:0]      bpp_code,
    output logic            bgr_order,
    output logic            be_byte,
    output logic            be_pixel,
    output logic [SW-1:0]   panel_width,
    output logic [SW-1:0]   panel_height,
    output logic [DW-1:0]   upper_base,
    output logic [DW-1:0]   lower_base,
    output logic            pal_we,
    output logic [PIW-1:0]  pal_idx,
    output logic [DW-1:0]   pal_wdata
);
    bus_state_e state_q, state_d;
    logic       accept;
    region_e    region;
    logic [3:0] widx;
    logic       dec_err;
    logic       reg_we;
    logic       pal_wr;

    logic [DW-1:0]     timing_q [NTIM];
    logic [DW-1:0]     ubase_q, lbase_q;
    logic [CTRL_W-1:0] ctrl_q;
    logic [NIRQ-1:0]   mask_q, raw_q;
    logic [DW-1:0]     pal_rd;
    logic [DW-1:0]     rd_mux;

    // Bus state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (bus_sel) state_d = ST_RESP;
            ST_RESP: state_d = ST_IDLE;
        endcase
    end

    assign accept = (state_q == ST_IDLE) && bus_sel;
    assign bus_ack = (state_q == ST_RESP);

    lcd_regif_decode #(
        .AW(AW), .NREG(13), .PAL_BASE(PAL_BASE), .PAL_DEPTH(PAL_DEPTH),
        .ID_BASE(ID_BASE), .ID_WORDS(8)
    ) u_dec (
        .addr(bus_addr), .wr(bus_wr), .strap_alt(strap_alt),
        .region(region), .widx(widx), .err(dec_err)
    );

    assign reg_we = accept && bus_wr && region == RGN_REG && !dec_err;
    assign pal_wr = accept && bus_wr && region == RGN_PAL;

    // Timing words
    for (genvar g = 0; g < NTIM; g++) begin : g_tim
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                             timing_q[g] <= '0;
            else if (reg_we && widx == 4'(g))       timing_q[g] <= bus_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ubase_q <= '0;
            lbase_q <= '0;
            ctrl_q  <= '0;
        end else if (reg_we) begin
            if (widx == IDX_UBASE) ubase_q <= bus_wdata;
            if (widx == IDX_LBASE) lbase_q <= bus_wdata;
            if (widx == IDX_CTRL)  ctrl_q  <= bus_wdata[CTRL_W-1:0];
        end
    end

    lcd_regif_irq #(.NIRQ(NIRQ)) u_irq (
        .clk(clk), .rst_n(rst_n),
        .mask_we(reg_we && widx == IDX_MASK),
        .clr_we(reg_we && widx == IDX_CLR),
        .wbits(bus_wdata[NIRQ-1:0]), .evt(int_evt),
        .mask_q(mask_q), .raw_q(raw_q), .irq(irq_out)
    );

    // Palette window is aligned to its depth, so the low address bits index it
    lcd_regif_palette #(.DW(DW), .DEPTH(PAL_DEPTH)) u_pal (
        .clk(clk), .we(pal_wr), .idx(bus_addr[PIW-1:0]),
        .wdata(bus_wdata), .rdata(pal_rd)
    );

    always_comb begin
        rd_mux = '0;
        unique case (region)
            RGN_REG: begin
                if (int'(widx) < NTIM) rd_mux = timing_q[widx[1:0]];
                else unique case (widx)
                    IDX_UBASE, IDX_UCUR: rd_mux = ubase_q;
                    IDX_LBASE, IDX_LCUR: rd_mux = lbase_q;
                    IDX_MASK:            rd_mux = DW'(mask_q);
                    IDX_CTRL:            rd_mux = DW'(ctrl_q);
                    IDX_RAW:             rd_mux = DW'(raw_q);
                    IDX_MIS:             rd_mux = DW'(raw_q & mask_q);
                    default:             rd_mux = '0;
                endcase
            end
            RGN_PAL:  rd_mux = pal_rd;
            RGN_ID:   rd_mux = DW'(id_byte(bus_addr[2:0]));
            RGN_NONE: rd_mux = '0;
        endcase
    end

    // Response outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata <= '0;
            bus_err   <= 1'b0;
            pal_we    <= 1'b0;
            pal_idx   <= '0;
            pal_wdata <= '0;
        end else begin
            bus_rdata <= (accept && !bus_wr) ? rd_mux : '0;
            bus_err   <= accept && dec_err;
            pal_we    <= pal_wr;
            if (pal_wr) begin
                pal_idx   <= bus_addr[PIW-1:0];
                pal_wdata <= bus_wdata;
            end
        end
    end

    assign disp_en      = ctrl_q[CB_EN] && ctrl_q[CB_PWR];
    assign bpp_code     = ctrl_q[CB_BPP +: 3];
    assign bgr_order    = ctrl_q[CB_BGR];
    assign be_byte      = ctrl_q[CB_BEBY];
    assign be_pixel     = ctrl_q[CB_BEPX];
    assign panel_width  = {timing_q[0][7:2] + 7'd1, 4'b0000};
    assign panel_height = {1'b0, timing_q[1][9:0]} + SW'(1);
    assign upper_base   = ubase_q;
    assign lower_base   = lbase_q;

    // R1
    ack_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_ack) |=> bus_ack);

    // R1
    ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |=> !bus_ack);

    // R11
    err_in_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> bus_ack);

    // R4
    size_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && bus_wr && !bus_ack) |=> ($stable(panel_width) && $stable(panel_height)));

    // R10
    pal_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pal_we |-> (bus_ack && !bus_err));

endmodule

// File: tb/lcd_regif_test.sv
module lcd_regif_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strap_alt = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [9:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [4:0]  int_evt = '0;
    logic        bus_ack, bus_err, irq_out, disp_en, bgr_order, be_byte, be_pixel, pal_we;
    logic [31:0] bus_rdata, upper_base, lower_base, pal_wdata;
    logic [2:0]  bpp_code;
    logic [10:0] panel_width, panel_height;
    logic [6:0]  pal_idx;

    lcd_regif uut (
        .clk(clk), .rst_n(rst_n), .strap_alt(strap_alt), .bus_sel(bus_sel),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_err(bus_err), .bus_rdata(bus_rdata),
        .int_evt(int_evt), .irq_out(irq_out), .disp_en(disp_en),
        .bpp_code(bpp_code), .bgr_order(bgr_order), .be_byte(be_byte),
        .be_pixel(be_pixel), .panel_width(panel_width), .panel_height(panel_height),
        .upper_base(upper_base), .lower_base(lower_base), .pal_we(pal_we),
        .pal_idx(pal_idx), .pal_wdata(pal_wdata)
    );

    always #5 clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;
    bit started = 0;
    bit evt_rand = 0;

    // Reference model state
    longint m_tim [4];
    longint m_ub = 0, m_lb = 0, m_mask = 0, m_ctrl = 0, m_raw = 0;
    longint m_pal [128];
    bit     e_ack = 0, e_err = 0, e_pwe = 0;
    longint e_rd = 0, e_pidx = 0, e_pwd = 0;
    string  e_tag = "R1";
    byte unsigned idtab [8] = '{8'h10, 8'h11, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    initial for (int i = 0; i < 4; i++) m_tim[i] = 0;
    initial for (int i = 0; i < 128; i++) m_pal[i] = 0;

    always @(posedge clk) begin
        started <= 1;
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) m_tim[i] = 0;
            m_ub = 0; m_lb = 0; m_mask = 0; m_ctrl = 0; m_raw = 0;
            e_ack = 0; e_err = 0; e_pwe = 0; e_rd = 0;
        end else begin
            bit acc;
            longint clr;
            int a, eff;
            acc = bus_sel && !e_ack;
            clr = 0;
            e_err = 0; e_pwe = 0; e_rd = 0;
            if (acc) begin
                a = int'(bus_addr);
                eff = a;
                if (strap_alt && a == 6) eff = 7;
                else if (strap_alt && a == 7) eff = 6;
                e_tag = (strap_alt && (a == 6 || a == 7)) ? "R3" : "R2";
                if (a <= 12) begin
                    if (eff >= 8) e_tag = (eff == 8 || eff == 9) ? "R6" : (eff == 10 ? "R11" : "R8");
                    if (!bus_wr) begin
                        case (eff)
                            0, 1, 2, 3: e_rd = m_tim[eff];
                            4, 11: e_rd = m_ub;
                            5, 12: e_rd = m_lb;
                            6: e_rd = m_mask;
                            7: e_rd = m_ctrl;
                            8: e_rd = m_raw;
                            9: e_rd = m_raw & m_mask;
                            default: e_rd = 0;
                        endcase
                    end else begin
                        case (eff)
                            0, 1, 2, 3: m_tim[eff] = longint'(bus_wdata);
                            4: m_ub = longint'(bus_wdata);
                            5: m_lb = longint'(bus_wdata);
                            6: m_mask = longint'(bus_wdata) & 'h1F;
                            7: m_ctrl = longint'(bus_wdata) & 'hFFF;
                            10: clr = longint'(bus_wdata) & 'h1F;
                            default: begin e_err = 1; e_tag = "R11"; end
                        endcase
                    end
                end else if (a >= 128 && a < 256) begin
                    e_tag = "R10";
                    if (bus_wr) begin
                        m_pal[a-128] = longint'(bus_wdata);
                        e_pwe = 1; e_pidx = a - 128; e_pwd = longint'(bus_wdata);
                    end else e_rd = m_pal[a-128];
                end else if (a >= 1016 && a < 1024) begin
                    e_tag = "R9";
                    if (bus_wr) e_err = 1; else e_rd = idtab[a-1016];
                end else begin
                    e_tag = "R11";
                    e_err = 1;
                end
            end
            e_ack = acc;
            m_raw = (m_raw & ~clr) | longint'(int_evt);
        end
    end

    // Compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (started && !done) begin
            chk("R1", "ack", bus_ack, e_ack);
            if (e_ack) begin
                chk("R11", "err", bus_err, e_err);
                chk(e_tag, "rdata", bus_rdata, e_rd);
            end
            chk("R4", "width", panel_width, ((m_tim[0] & 'hFC) + 4) * 4);
            chk("R4", "height", panel_height, (m_tim[1] & 'h3FF) + 1);
            chk("R5", "disp_en", disp_en, m_ctrl[0] & m_ctrl[11]);
            chk("R5", "bpp", bpp_code, (m_ctrl >> 1) & 7);
            chk("R5", "bgr", bgr_order, m_ctrl[8]);
            chk("R5", "be_byte", be_byte, m_ctrl[9]);
            chk("R5", "be_pixel", be_pixel, m_ctrl[10]);
            chk("R2", "upper_base", upper_base, m_ub);
            chk("R2", "lower_base", lower_base, m_lb);
            chk("R7", "irq", irq_out, ((m_raw & m_mask) != 0) ? 1 : 0);
            chk("R10", "pal_we", pal_we, e_pwe);
            if (e_pwe) begin
                chk("R10", "pal_idx", pal_idx, e_pidx);
                chk("R10", "pal_wdata", pal_wdata, e_pwd);
            end
        end
    end

    always @(negedge clk) if (evt_rand) int_evt <= ($urandom % 4 == 0) ? 5'($urandom) : 5'd0;

    task automatic access(input bit wr, input int addr, input longint data);
        @(negedge clk);
        bus_sel = 1; bus_wr = wr; bus_addr = 10'(addr); bus_wdata = 32'(data);
        @(negedge clk);
        bus_sel = 0;
    endtask

    task automatic pulse_evt(input logic [4:0] v);
        @(negedge clk);
        int_evt = v;
        @(negedge clk);
        int_evt = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        repeat (2) @(negedge clk);
        // R2 R4 timing words and panel size
        for (int i = 0; i < 4; i++) access(0, i, 0);
        access(1, 0, 'h3C); access(1, 1, 'h1DF);
        access(1, 2, 'hDEADBEEF); access(1, 3, 'h12345678);
        for (int i = 0; i < 4; i++) access(0, i, 0);
        access(1, 0, 'hFFFF_FFFF); access(1, 1, 'hFFFF_FC00);
        // R8 base and current-address reads
        access(1, 4, 'h8000_1000); access(1, 5, 'h0004_2000);
        for (int i = 4; i <= 5; i++) access(0, i, 0);
        access(0, 11, 0); access(0, 12, 0);
        // R5 control: enable without power, then both, then other fields
        access(1, 7, 'h001); access(1, 7, 'h80B); access(1, 7, 'h70E);
        access(1, 7, 'hFFFF_F801); access(0, 7, 0);
        // R6 R7 status, mask, clear
        access(1, 6, 'h15);
        pulse_evt(5'h02); access(0, 8, 0); access(0, 9, 0);
        pulse_evt(5'h04); access(0, 9, 0);
        access(1, 10, 'h04); access(0, 8, 0);
        @(negedge clk); int_evt = 5'h02; bus_sel = 1; bus_wr = 1; bus_addr = 10; bus_wdata = 'h1F;
        @(negedge clk); int_evt = 0; bus_sel = 0;
        access(0, 8, 0); access(1, 10, 'h1F); access(0, 10, 0);
        // R3 strap swap
        strap_alt = 1;
        access(1, 6, 'h801); access(1, 7, 'h0A);
        access(0, 6, 0); access(0, 7, 0);
        strap_alt = 0;
        access(0, 6, 0); access(0, 7, 0);
        // R10 palette fill and read-back
        for (int i = 0; i < 128; i++) access(1, 128 + i, 32'(i * 'h01010101 + 7));
        access(0, 128, 0); access(0, 133, 0); access(0, 255, 0);
        // R9 identification
        for (int i = 0; i < 8; i++) access(0, 1016 + i, 0);
        access(1, 1016, 'hFF);
        // R11 unmapped and read-only
        access(0, 13, 0); access(0, 64, 0); access(0, 1015, 0);
        access(1, 13, 'h55); access(1, 8, 1); access(1, 11, 1); access(1, 12, 1);
        // R1 request held through the ack cycle
        @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = 4;
        @(negedge clk); @(negedge clk); bus_sel = 0;
        // Random mix
        evt_rand = 1;
        for (int k = 0; k < 400; k++) begin
            int sel;
            int ad;
            sel = $urandom % 5;
            case (sel)
                0, 1: ad = $urandom % 13;
                2: ad = 128 + ($urandom % 128);
                3: ad = 1016 + ($urandom % 8);
                default: ad = ($urandom % 2) ? 14 : 600;
            endcase
            strap_alt = ($urandom % 4 == 0);
            access($urandom % 2, ad, $urandom);
        end
        evt_rand = 0;
        repeat (4) @(negedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_cmp++; n_bad++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule